// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block connects a processor bus to three 8-bit parallel ports, called A, B and C here, and holds one control register. The processor reaches the block through an active-low select, active-low read and write strobes, a two-bit register address and an 8-bit data bus. All logic runs on one clock with a synchronous active-high reset. The bus strobes are sampled on that clock, so a write takes effect on the first clock edge at which select and write are both seen low.

Two kinds of word can be written to the control address. A configuration word sets the direction of ports A and B and of the two halves of port C. It also chooses plain I/O or strobed handshake operation for ports A and B. A single-line word sets or clears one port C output line. In handshake operation, fixed port C lines become strobe, acknowledge, buffer-flag and interrupt lines for port A or B. Each pin is modelled as a separate input, output and output-enable vector.

Top module: `pio_three_port`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects control. A write while `cs_n` is high changes no port latch or line.
- R2: After reset every output enable is low, all output latches are zero, and a read of address 3 returns 9Bh (all ports input, plain I/O).
- R3: A control write with bit 7 = 1 is a configuration word. Bits 6-5 give the A mode, bit 4 the A direction (1 = input), bit 3 the upper C direction, bit 2 the B mode, bit 1 the B direction and bit 0 the lower C direction. Reading address 3 returns the stored word with bit 7 set. The word 83h makes A an output, B an input, lower C an input and upper C an output.
- R4: A read of an output port returns its last written value. A read of a plain-I/O input port returns the live pins.
- R5: Port C lines 0-3 follow the lower direction bit and lines 4-7 follow the upper one, independently of each other.
- R6: A control write with bit 7 = 0 puts bit 0 into the port C latch line chosen by bits 3-1. No other line changes, and the configuration stays as it was.
- R7: A configuration write clears the A, B and C output latches and the handshake state.
- R8: With A in handshake input, a low level on C line 4 captures the A pins and raises the buffer-full flag on line 5. Releasing the strobe while the buffer is full raises the interrupt on line 3. Reads of A return the captured byte. The end of an A read clears both the flag and the interrupt.
- R9: With A in handshake output, a write to A drives line 7 low (buffer loaded, active low). A low on acknowledge line 6 returns line 7 high. Releasing the acknowledge raises the interrupt on line 3, and the next write to A clears it.
- R10: In handshake mode, port B uses C line 2 as its strobe or acknowledge, line 1 as its buffer flag and line 0 as its interrupt, with the same behaviour as port A.
- R11: Handshake output lines are always driven, and handshake strobe or acknowledge lines are never driven. A read of port C returns the handshake values on the lines they own.
- R12: Any nonzero value in the A mode field selects handshake operation for port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| d_in | input | 8 | Write data from the bus |
| d_out | output | 8 | Read data to the bus |
| d_oe | output | 1 | Bus drive enable during a read |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C drive enables |

## Verification
The hardest state to reach from the ports is the one where a handshake input port holds a captured byte while its pins already show something else, the buffer flag and interrupt are both set, and a read of port C has to report them. The stimulus gets there in a set order. It writes the configuration word first, then pulls the strobe line low for one cycle, then changes the port pins, then releases the strobe. Only after that does it read port C and then the data port, checking that the flag clears only once the data read has ended.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DW = 8;
    localparam int CW = 8;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } sel_e;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    // port C line positions used by the handshakes
    localparam int LN_B_INTR = 0;
    localparam int LN_B_FLAG = 1;
    localparam int LN_B_STB  = 2;
    localparam int LN_A_INTR = 3;
    localparam int LN_A_STBI = 4;
    localparam int LN_A_IBF  = 5;
    localparam int LN_A_ACKO = 6;
    localparam int LN_A_OBF  = 7;

    typedef struct packed {
        logic [CW-1:0] own_out;
        logic [CW-1:0] own_in;
    } c_roles_t;

    function automatic logic a_handshake(cfg_t c);
        return |c.a_mode;
    endfunction

    function automatic c_roles_t c_roles(cfg_t c);
        c_roles_t r;
        r = '0;
        if (c.b_mode) begin
            r.own_out[LN_B_INTR] = 1'b1;
            r.own_out[LN_B_FLAG] = 1'b1;
            r.own_in[LN_B_STB]   = 1'b1;
        end
        if (a_handshake(c)) begin
            r.own_out[LN_A_INTR] = 1'b1;
            if (c.a_in) begin
                r.own_in[LN_A_STBI] = 1'b1;
                r.own_out[LN_A_IBF] = 1'b1;
            end else begin
                r.own_in[LN_A_ACKO] = 1'b1;
                r.own_out[LN_A_OBF] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic       wr_stb,
    output sel_e       wr_sel,
    output logic       rd_done,
    output sel_e       rd_sel,
    output logic       rd_act
);

    logic wr_act;
    logic wr_q;
    logic rd_q;
    sel_e rd_sel_q;

    assign wr_act  = !cs_n && !wr_n;
    assign rd_act  = !cs_n && !rd_n;
    assign wr_stb  = wr_act && !wr_q;
    assign wr_sel  = sel_e'(addr);
    assign rd_done = rd_q && !rd_act;
    assign rd_sel  = rd_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            rd_sel_q <= SEL_A;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (rd_act) begin
                rd_sel_q <= sel_e'(addr);
            end
        end
    end

endmodule

// File: rtl/pio_hs_port.sv
module pio_hs_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hs_en,
    input  logic         dir_in,
    input  logic         clr,
    input  logic         wr_stb,
    input  logic [W-1:0] wd,
    input  logic         rd_done,
    input  logic [W-1:0] pins,
    input  logic         hs_n,
    output logic [W-1:0] lat,
    output logic         flag,
    output logic         intr,
    output logic [W-1:0] rd_val
);

    logic [W-1:0] lat_q;
    logic [W-1:0] cap_q;
    logic         ibf_q;
    logic         obf_n_q;
    logic         intr_q;
    logic         hs_q;
    logic         hs_fall;
    logic         hs_rise;

    assign hs_fall = hs_q && !hs_n;
    assign hs_rise = !hs_q && hs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b1;
        end else begin
            hs_q <= hs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lat_q   <= '0;
            cap_q   <= '0;
            ibf_q   <= 1'b0;
            obf_n_q <= 1'b1;
            intr_q  <= 1'b0;
        end else begin
            if (wr_stb) begin
                lat_q <= wd;
            end
            if (hs_en && dir_in) begin
                if (hs_fall) begin
                    cap_q <= pins;
                    ibf_q <= 1'b1;
                end
                if (hs_rise && ibf_q) begin
                    intr_q <= 1'b1;
                end
                if (rd_done) begin
                    ibf_q  <= 1'b0;
                    intr_q <= 1'b0;
                end
            end else if (hs_en) begin
                if (wr_stb) begin
                    obf_n_q <= 1'b0;
                    intr_q  <= 1'b0;
                end else begin
                    if (hs_fall) begin
                        obf_n_q <= 1'b1;
                    end
                    if (hs_rise) begin
                        intr_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign lat    = lat_q;
    assign flag   = dir_in ? ibf_q : obf_n_q;
    assign intr   = intr_q;
    assign rd_val = !dir_in ? lat_q : (hs_en ? cap_q : pins);

endmodule

// File: rtl/pio_portc.sv
module pio_portc
    import pio_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [CW-1:0] c_lat,
    input  logic [CW-1:0] pc_in,
    input  logic          a_flag,
    input  logic          a_intr,
    input  logic          b_flag,
    input  logic          b_intr,
    output logic [CW-1:0] pc_out,
    output logic [CW-1:0] pc_oe,
    output logic [CW-1:0] c_rd
);

    localparam int HALF = CW / 2;

    c_roles_t      roles;
    logic [CW-1:0] hs_val;
    logic [CW-1:0] grp_out;

    assign roles = c_roles(cfg);

    always_comb begin
        hs_val            = '0;
        hs_val[LN_B_INTR] = b_intr;
        hs_val[LN_B_FLAG] = b_flag;
        hs_val[LN_A_INTR] = a_intr;
        hs_val[LN_A_IBF]  = a_flag;
        hs_val[LN_A_OBF]  = a_flag;
    end

    genvar gi;
    generate
        for (gi = 0; gi < CW; gi++) begin : g_line
            if (gi < HALF) begin : g_lo
                assign grp_out[gi] = !cfg.cl_in;
            end else begin : g_hi
                assign grp_out[gi] = !cfg.cu_in;
            end
            assign pc_oe[gi]  = roles.own_out[gi] ? 1'b1
                              : (roles.own_in[gi] ? 1'b0 : grp_out[gi]);
            assign pc_out[gi] = roles.own_out[gi] ? hs_val[gi] : c_lat[gi];
            assign c_rd[gi]   = roles.own_out[gi] ? hs_val[gi]
                              : ((!roles.own_in[gi] && grp_out[gi]) ? c_lat[gi] : pc_in[gi]);
        end
    endgenerate

endmodule

// File: rtl/pio_three_port.sv
module pio_three_port
    import pio_pkg::*;
#(
    parameter int DW_P = pio_pkg::DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [1:0]      addr,
    input  logic [DW_P-1:0] d_in,
    output logic [DW_P-1:0] d_out,
    output logic            d_oe,
    input  logic [DW_P-1:0] pa_in,
    output logic [DW_P-1:0] pa_out,
    output logic [DW_P-1:0] pa_oe,
    input  logic [DW_P-1:0] pb_in,
    output logic [DW_P-1:0] pb_out,
    output logic [DW_P-1:0] pb_oe,
    input  logic [CW-1:0]   pc_in,
    output logic [CW-1:0]   pc_out,
    output logic [CW-1:0]   pc_oe
);

    localparam int NP = 2;
    localparam int SELW = $clog2(CW);

    logic wr_stb;
    sel_e wr_sel;
    logic rd_done;
    sel_e rd_sel;
    logic rd_act;

    cfg_t          cfg_q;
    logic [CW-1:0] c_lat;
    logic          mset_stb;
    logic          bsr_stb;
    logic          wr_a_stb;
    logic          a_hs_in;
    logic          a_hs_out;
    logic          a_flag;

    logic [NP-1:0][DW_P-1:0] p_pins;
    logic [NP-1:0][DW_P-1:0] p_lat;
    logic [NP-1:0][DW_P-1:0] p_rd;
    logic [NP-1:0]           p_hs_en;
    logic [NP-1:0]           p_dir_in;
    logic [NP-1:0]           p_wr;
    logic [NP-1:0]           p_rdd;
    logic [NP-1:0]           p_hs_n;
    logic [NP-1:0]           p_flag;
    logic [NP-1:0]           p_intr;
    logic [CW-1:0]           c_rd;

    pio_bus_if u_bus (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .rd_done (rd_done),
        .rd_sel  (rd_sel),
        .rd_act  (rd_act)
    );

    assign mset_stb = wr_stb && (wr_sel == SEL_CTL) && d_in[CW-1];
    assign bsr_stb  = wr_stb && (wr_sel == SEL_CTL) && !d_in[CW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (mset_stb) begin
            cfg_q <= cfg_t'(d_in[CW-2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mset_stb) begin
            c_lat <= '0;
        end else if (bsr_stb) begin
            c_lat[d_in[SELW:1]] <= d_in[0];
        end else if (wr_stb && wr_sel == SEL_C) begin
            c_lat <= d_in[CW-1:0];
        end
    end

    // per-port configuration
    assign p_pins[0]   = pa_in;
    assign p_pins[1]   = pb_in;
    assign p_hs_en[0]  = a_handshake(cfg_q);
    assign p_hs_en[1]  = cfg_q.b_mode;
    assign p_dir_in[0] = cfg_q.a_in;
    assign p_dir_in[1] = cfg_q.b_in;
    assign p_hs_n[0]   = cfg_q.a_in ? pc_in[LN_A_STBI] : pc_in[LN_A_ACKO];
    assign p_hs_n[1]   = pc_in[LN_B_STB];

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_port
            assign p_wr[gp]  = wr_stb && (wr_sel == sel_e'(gp));
            assign p_rdd[gp] = rd_done && (rd_sel == sel_e'(gp));

            pio_hs_port #(.W(DW_P)) u_port (
                .clk     (clk),
                .rst     (rst),
                .hs_en   (p_hs_en[gp]),
                .dir_in  (p_dir_in[gp]),
                .clr     (mset_stb),
                .wr_stb  (p_wr[gp]),
                .wd      (d_in),
                .rd_done (p_rdd[gp]),
                .pins    (p_pins[gp]),
                .hs_n    (p_hs_n[gp]),
                .lat     (p_lat[gp]),
                .flag    (p_flag[gp]),
                .intr    (p_intr[gp]),
                .rd_val  (p_rd[gp])
            );
        end
    endgenerate

    pio_portc u_portc (
        .cfg    (cfg_q),
        .c_lat  (c_lat),
        .pc_in  (pc_in),
        .a_flag (p_flag[0]),
        .a_intr (p_intr[0]),
        .b_flag (p_flag[1]),
        .b_intr (p_intr[1]),
        .pc_out (pc_out),
        .pc_oe  (pc_oe),
        .c_rd   (c_rd)
    );

    assign wr_a_stb = p_wr[0];
    assign a_hs_in  = p_hs_en[0] && cfg_q.a_in;
    assign a_hs_out = p_hs_en[0] && !cfg_q.a_in;
    assign a_flag   = p_flag[0];

    assign pa_out = p_lat[0];
    assign pb_out = p_lat[1];
    assign pa_oe  = {DW_P{!cfg_q.a_in}};
    assign pb_oe  = {DW_P{!cfg_q.b_in}};

    assign d_oe = rd_act;

    always_comb begin
        unique case (sel_e'(addr))
            SEL_A:   d_out = p_rd[0];
            SEL_B:   d_out = p_rd[1];
            SEL_C:   d_out = c_rd;
            default: d_out = {1'b1, cfg_q};
        endcase
    end

endmodule

// File: rtl/pio_three_port_chk.sv
module pio_three_port_chk
    import pio_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pb_out,
    input logic [DW-1:0] pa_oe,
    input logic [CW-1:0] pc_in,
    input logic [CW-1:0] pc_out,
    input logic [CW-1:0] c_lat,
    input logic          mset_stb,
    input logic          bsr_stb,
    input logic          wr_a_stb,
    input logic          a_hs_in,
    input logic          a_hs_out,
    input logic          a_flag
);

    a_r1_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(c_lat)));

    a_r3_port_dir_uniform: assert property (@(posedge clk) disable iff (rst)
        (pa_oe == '0) || (pa_oe == '1));

    a_r6_single_line: assert property (@(posedge clk) disable iff (rst)
        bsr_stb |=> ($countones(c_lat ^ $past(c_lat)) <= 1));

    a_r7_config_clears: assert property (@(posedge clk) disable iff (rst)
        mset_stb |=> (pa_out == '0 && pb_out == '0 && c_lat == '0));

    a_r8_full_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(a_flag) && a_hs_in && $past(a_hs_in)) |-> !$past(pc_in[LN_A_STBI]));

    a_r9_loaded_after_write: assert property (@(posedge clk) disable iff (rst)
        (wr_a_stb && a_hs_out) |=> !pc_out[LN_A_OBF]);

endmodule

bind pio_three_port pio_three_port_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .pa_out   (pa_out),
    .pb_out   (pb_out),
    .pa_oe    (pa_oe),
    .pc_in    (pc_in),
    .pc_out   (pc_out),
    .c_lat    (c_lat),
    .mset_stb (mset_stb),
    .bsr_stb  (bsr_stb),
    .wr_a_stb (wr_a_stb),
    .a_hs_in  (a_hs_in),
    .a_hs_out (a_hs_out),
    .a_flag   (a_flag)
);

// File: tb/test_pio_three_port.sv
module test_pio_three_port;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam int WDOG = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pa_out;
    logic [7:0] pa_oe;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pb_out;
    logic [7:0] pb_oe;
    logic [7:0] pc_in = 8'hFF;
    logic [7:0] pc_out;
    logic [7:0] pc_oe;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pio_three_port i_pio_three_port (
        .clk (clk), .rst (rst), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .d_in (d_in), .d_out (d_out), .d_oe (d_oe),
        .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    // {cfg, wr_addr, wr_data, pa, pb, pc, rd_addr, expected}
    localparam logic [51:0] VEC [NVEC] = '{
        {8'h83, 2'd0, 8'h5A, 8'hFF, 8'h00, 8'h00, 2'd0, 8'h5A},
        {8'h83, 2'd1, 8'h11, 8'h00, 8'hC3, 8'h00, 2'd1, 8'hC3},
        {8'h83, 2'd2, 8'hA5, 8'h00, 8'h00, 8'h3C, 2'd2, 8'hAC},
        {8'h88, 2'd2, 8'hA5, 8'h00, 8'h00, 8'h3C, 2'd2, 8'h35},
        {8'h9B, 2'd0, 8'h77, 8'h12, 8'h00, 8'h00, 2'd0, 8'h12},
        {8'h80, 2'd1, 8'hE7, 8'h00, 8'h00, 8'h00, 2'd1, 8'hE7},
        {8'h80, 2'd3, 8'h0F, 8'h00, 8'h00, 8'hFF, 2'd2, 8'h80},
        {8'h80, 2'd3, 8'h05, 8'h00, 8'h00, 8'hFF, 2'd2, 8'h04},
        {8'h80, 2'd0, 8'h3C, 8'h00, 8'h00, 8'h00, 2'd3, 8'h80},
        {8'h83, 2'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 2'd2, 8'hF0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; d_in = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        d = d_out;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 pa_oe", pa_oe, 8'h00);
        check("R2 pb_oe", pb_oe, 8'h00);
        check("R2 pc_oe", pc_oe, 8'h00);
        check("R2 pa_out", pa_out, 8'h00);
        bus_read(2'd3, rv);
        check("R2 control readback", rv, 8'h9B);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(2'd3, VEC[i][51:44]);
            bus_write(VEC[i][43:42], VEC[i][41:34]);
            pa_in = VEC[i][33:26];
            pb_in = VEC[i][25:18];
            pc_in = VEC[i][17:10];
            bus_read(VEC[i][9:8], rv);
            check($sformatf("table R3 R4 R5 R6 vector %0d", i), rv, VEC[i][7:0]);
        end
        pc_in = 8'hFF;

        // R3 direction of 83h
        bus_write(2'd3, 8'h83);
        check("R3 83h pa_oe", pa_oe, 8'hFF);
        check("R3 83h pb_oe", pb_oe, 8'h00);
        check("R5 83h pc_oe", pc_oe, 8'hF0);

        // R1 unselected write
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'hAA);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; d_in = 8'h55;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        check("R1 write ignored without select", pa_out, 8'hAA);

        // R6 single line, configuration kept
        bus_write(2'd3, 8'h07);
        @(negedge clk);
        check("R6 line 3 set", pc_out, 8'h08);
        check("R6 config kept", pa_oe, 8'hFF);
        check("R6 pa latch kept", pa_out, 8'hAA);
        bus_write(2'd3, 8'h06);
        @(negedge clk);
        check("R6 line 3 cleared", pc_out, 8'h00);

        // R7 configuration clears latches
        bus_write(2'd1, 8'h3D);
        bus_write(2'd3, 8'h80);
        @(negedge clk);
        check("R7 pa cleared", pa_out, 8'h00);
        check("R7 pb cleared", pb_out, 8'h00);

        // R8 / R11 port A handshake input
        pa_in = 8'h9E;
        bus_write(2'd3, 8'hB3);
        @(negedge clk);
        check("R11 A input pc_oe", pc_oe, 8'hE8);
        check("R8 buffer empty", {7'd0, pc_out[5]}, 8'h00);
        pc_in[4] = 1'b0;
        @(negedge clk);
        check("R8 buffer full", {7'd0, pc_out[5]}, 8'h01);
        check("R8 no interrupt yet", {7'd0, pc_out[3]}, 8'h00);
        pa_in = 8'h55;
        pc_in[4] = 1'b1;
        @(negedge clk);
        check("R8 interrupt", {7'd0, pc_out[3]}, 8'h01);
        bus_read(2'd2, rv);
        check("R11 port C status read", rv, 8'h3F);
        check("R8 flag kept after C read", {7'd0, pc_out[5]}, 8'h01);
        bus_read(2'd0, rv);
        check("R8 captured data", rv, 8'h9E);
        check("R8 flag cleared", {7'd0, pc_out[5]}, 8'h00);
        check("R8 interrupt cleared", {7'd0, pc_out[3]}, 8'h00);

        // R9 port A handshake output
        bus_write(2'd3, 8'hA3);
        @(negedge clk);
        check("R11 A output pc_oe", pc_oe, 8'hB8);
        check("R9 idle high", {7'd0, pc_out[7]}, 8'h01);
        bus_write(2'd0, 8'hC7);
        @(negedge clk);
        check("R9 data out", pa_out, 8'hC7);
        check("R9 loaded low", {7'd0, pc_out[7]}, 8'h00);
        pc_in[6] = 1'b0;
        @(negedge clk);
        check("R9 ack releases", {7'd0, pc_out[7]}, 8'h01);
        check("R9 no interrupt during ack", {7'd0, pc_out[3]}, 8'h00);
        pc_in[6] = 1'b1;
        @(negedge clk);
        check("R9 interrupt", {7'd0, pc_out[3]}, 8'h01);
        bus_write(2'd0, 8'h01);
        @(negedge clk);
        check("R9 interrupt cleared by write", {7'd0, pc_out[3]}, 8'h00);

        // R10 port B handshake input
        pb_in = 8'h6B;
        bus_write(2'd3, 8'h9F);
        @(negedge clk);
        check("R10 B pc_oe", pc_oe, 8'h03);
        pc_in[2] = 1'b0;
        @(negedge clk);
        pb_in = 8'h00;
        pc_in[2] = 1'b1;
        @(negedge clk);
        check("R10 B full", {7'd0, pc_out[1]}, 8'h01);
        check("R10 B interrupt", {7'd0, pc_out[0]}, 8'h01);
        bus_read(2'd1, rv);
        check("R10 B captured", rv, 8'h6B);
        check("R10 B flag cleared", {7'd0, pc_out[1]}, 8'h00);

        // R12 mode field 10 acts as handshake
        bus_write(2'd3, 8'hDB);
        @(negedge clk);
        check("R12 mode 2 value handshake", pc_oe, 8'h28);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule